// File: doc/BRIEF.md
# Multi-Mode Interval Timer

A 16-bit up-counter with a period register, built for a peripheral subsystem. It counts either the system clock or rising edges of an external clock pin, after a prescaler with four selectable ratios. When a counting tick arrives while the count equals the period, the count returns to zero and a sticky interrupt flag is raised. Three control bits choose one of four modes: a plain timer, a timer that counts only while a gate input is high, and two external-edge counters. One counter uses the prescaled edges directly. The other passes the prescaler output through a resynchronizing stage before it reaches the count.

Software uses a simple register port. A single-cycle write selects one of four registers by address, and the read data follows the read address combinationally. The flag drives the interrupt output directly and stays set until software clears it.

Top module: `mm_timer`

## Requirements
- R1: After reset the control word is 0, the count is 0, the period is 16'hFFFF and the flag and irq_o are 0.
- R2: In every mode except the gated one, a counting tick that arrives while count equals period sets the count to 0 and sets the flag on the same clock edge. A tick on any other value adds one to the count.
- R3: With control bit 1 (clock source) = 0 and bit 6 (gate enable) = 0, a tick arrives on every clock, divided by the prescaler. Control bit 2 (sync) has no effect in this mode.
- R4: The flag stays set until a write to address 3 with wr_data[0] = 0 clears it. A write to address 3 with bit 0 = 1 has no effect. A set and a clear in the same cycle leave the flag set.
- R5: Control bits 5:4 select the prescale ratio: 00 = 1:1, 01 = 1:8, 10 = 1:64, 11 = 1:256.
- R6: With bit 1 = 0 and bit 6 = 1 (gated mode), clock ticks feed the prescaler only in cycles where gate_i is high.
- R7: In gated mode with the run bit set, a falling edge of gate_i (high at one clock edge, low at the next) sets the flag. A period match in gated mode still wraps the count but does not set the flag.
- R8: With bit 1 = 1 and bit 2 = 0 (direct counter), each rising edge of ext_clk_i (low at one clock edge, high at the next) feeds the prescaler. A prescaler output increments the count on that same clock edge.
- R9: With bit 1 = 1 and bit 2 = 1 (resynchronized counter), the prescaler output passes through two flops and a rising-edge detect, so the count moves two clocks later than in the direct counter. Bit 6 has no effect in this mode.
- R10: A write to address 0 clears the prescaler and the resynchronizer, and no increment happens in that cycle. A write to address 1 loads the count on that edge, takes priority over any tick, and clears the prescaler.
- R11: While control bit 15 (run) is 0, the count holds and no tick or gate edge sets the flag.
- R12: The addresses are 0 = control (only bits 15, 6, 5, 4, 2 and 1 are stored, the rest read 0), 1 = count, 2 = period and 3 = status (flag in bit 0). rd_data shows the register at rd_addr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Address of the register to write |
| wr_data | input | 16 | Data to write |
| rd_addr | input | 2 | Address of the register to read |
| rd_data | output | 16 | Contents of the register at rd_addr |
| ext_clk_i | input | 1 | External count input, sampled by clk |
| gate_i | input | 1 | Gate input for gated mode |
| irq_o | output | 1 | Interrupt flag |

## Verification
The bench builds the block with its default parameters: a 16-bit count, prescaler shifts of 3, 6 and 8, and two resynchronizing stages. These values make the two-clock delay of the resynchronized counter directly observable against the direct counter. Small period values keep every wrap within a few clock edges. The 1:256 ratio can be reached inside about a thousand cycles, which covers the full width of the prescaler counter. The bench also holds a flag clear across a wrap to exercise the set-over-clear rule, and writes the control word while a resynchronized pulse is still in flight.

// File: rtl/mm_timer_pkg.sv
package mm_timer_pkg;

   typedef enum logic [1:0] {
      MODE_TIMER = 2'd0,
      MODE_GATED = 2'd1,
      MODE_SYNC  = 2'd2,
      MODE_ASYNC = 2'd3
   } tmr_mode_e;

   localparam int BIT_SRC  = 1;
   localparam int BIT_SYNC = 2;
   localparam int BIT_PSLO = 4;
   localparam int BIT_GATE = 6;
   localparam int BIT_RUN  = 15;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_CNT  = 2'd1;
   localparam logic [1:0] A_PER  = 2'd2;
   localparam logic [1:0] A_STAT = 2'd3;

   function automatic tmr_mode_e mode_of(input logic src, input logic syn, input logic gte);
      if (!src) return gte ? MODE_GATED : MODE_TIMER;
      return syn ? MODE_SYNC : MODE_ASYNC;
   endfunction

endpackage

// File: rtl/mm_timer_psc.sv
module mm_timer_psc #(
   parameter int PSC_W = 8,
   parameter int SH1   = 3,
   parameter int SH2   = 6,
   parameter int SH3   = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       src,
   input  logic [1:0] sel,
   output logic       fire
);
   localparam logic [PSC_W-1:0] LIM1 = PSC_W'((33'd1 << SH1) - 33'd1);
   localparam logic [PSC_W-1:0] LIM2 = PSC_W'((33'd1 << SH2) - 33'd1);
   localparam logic [PSC_W-1:0] LIM3 = PSC_W'((33'd1 << SH3) - 33'd1);

   if (SH1 > PSC_W || SH2 > PSC_W || SH3 > PSC_W) begin : g_bad_shift
      $error("prescaler shift exceeds PSC_W");
   end
   if (!(SH1 < SH2 && SH2 < SH3)) begin : g_bad_order
      $error("prescaler shifts must rise");
   end

   logic [PSC_W-1:0] pcnt_q;
   logic [PSC_W-1:0] lim;

   always_comb begin
      case (sel)
         2'd0:    lim = '0;
         2'd1:    lim = LIM1;
         2'd2:    lim = LIM2;
         default: lim = LIM3;
      endcase
   end

   assign fire = src & ~clr & (pcnt_q == lim);

   always_ff @(posedge clk) begin
      if (!rst_n || clr || fire) pcnt_q <= '0;
      else if (src)              pcnt_q <= pcnt_q + 1'b1;
   end
endmodule

// File: rtl/mm_timer_sync.sv
module mm_timer_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic d,
   output logic pulse
);
   if (STAGES < 1) begin : g_bad_stages
      $error("STAGES must be at least 1");
   end

   logic [STAGES:0] st_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) st_q[0] <= 1'b0;
      else               st_q[0] <= d;
   end

   for (genvar i = 1; i <= STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n || clr) st_q[i] <= 1'b0;
         else               st_q[i] <= st_q[i-1];
      end
   end

   assign pulse = st_q[STAGES-1] & ~st_q[STAGES];
endmodule

// File: rtl/mm_timer.sv
module mm_timer
   import mm_timer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PSC_W       = 8,
   parameter int PS_SH1      = 3,
   parameter int PS_SH2      = 6,
   parameter int PS_SH3      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   input  logic             ext_clk_i,
   input  logic             gate_i,
   output logic             irq_o
);
   localparam logic [CNT_W-1:0] CTL_MASK = CNT_W'(17'h08076);

   if (CNT_W < 16) begin : g_bad_width
      $error("CNT_W must hold the 16-bit control word");
   end

   logic [CNT_W-1:0] ctrl_q, cnt_q, per_q;
   logic             flag_q, ext_q, gate_q;
   tmr_mode_e        mode;
   logic             run, wr_ctl, wr_cnt, clr_psc;
   logic             ext_rise, gate_fall, src, fire, sync_pulse, tick, set_flag;

   assign mode      = mode_of(ctrl_q[BIT_SRC], ctrl_q[BIT_SYNC], ctrl_q[BIT_GATE]);
   assign run       = ctrl_q[BIT_RUN];
   assign wr_ctl    = wr_en && wr_addr == A_CTRL;
   assign wr_cnt    = wr_en && wr_addr == A_CNT;
   assign clr_psc   = wr_ctl | wr_cnt;
   assign ext_rise  = ext_clk_i & ~ext_q;
   assign gate_fall = gate_q & ~gate_i;

   always_comb begin
      case (mode)
         MODE_TIMER: src = run;
         MODE_GATED: src = run & gate_i;
         default:    src = run & ext_rise;
      endcase
   end

   mm_timer_psc #(.PSC_W(PSC_W), .SH1(PS_SH1), .SH2(PS_SH2), .SH3(PS_SH3)) psc_i (
      .clk(clk), .rst_n(rst_n), .clr(clr_psc), .src(src),
      .sel(ctrl_q[BIT_PSLO+1:BIT_PSLO]), .fire(fire)
   );

   mm_timer_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .clr(wr_ctl), .d(fire), .pulse(sync_pulse)
   );

   assign tick = ((mode == MODE_SYNC) ? sync_pulse : fire) & ~clr_psc;

   assign set_flag = (tick && cnt_q == per_q && mode != MODE_GATED) ||
                     (run && mode == MODE_GATED && gate_fall);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ext_q  <= 1'b0;
         gate_q <= 1'b0;
      end else begin
         ext_q  <= ext_clk_i;
         gate_q <= gate_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         per_q  <= '1;
      end else if (wr_en) begin
         if (wr_addr == A_CTRL) ctrl_q <= wr_data & CTL_MASK;
         if (wr_addr == A_PER)  per_q  <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt_q <= '0;
      else if (wr_cnt)          cnt_q <= wr_data;
      else if (tick) begin
         if (cnt_q == per_q)    cnt_q <= '0;
         else                   cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                                          flag_q <= 1'b0;
      else if (set_flag)                                   flag_q <= 1'b1;
      else if (wr_en && wr_addr == A_STAT && !wr_data[0])  flag_q <= 1'b0;
   end

   always_comb begin
      case (rd_addr)
         A_CTRL:  rd_data = ctrl_q;
         A_CNT:   rd_data = cnt_q;
         A_PER:   rd_data = per_q;
         default: rd_data = CNT_W'(flag_q);
      endcase
   end

   assign irq_o = flag_q;
endmodule

// File: rtl/mm_timer_chk.sv
module mm_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [CNT_W-1:0] wr_data,
   input logic             gate_i,
   input logic             irq_o,
   input logic [CNT_W-1:0] ctrl_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] per_q,
   input logic             gate_q
);
   logic plain_fast;
   assign plain_fast = ctrl_q[15] && !ctrl_q[1] && !ctrl_q[6] && ctrl_q[5:4] == 2'b00;

   // R2
   wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      plain_fast && !wr_en && cnt_q == per_q |=> cnt_q == '0 && irq_o);

   // R3
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      plain_fast && !wr_en && cnt_q != per_q |=> cnt_q == $past(cnt_q) + 1'b1);

   // R4
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o && !(wr_en && wr_addr == 2'd3 && !wr_data[0]) |=> irq_o);

   // R7
   gate_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[15] && !ctrl_q[1] && ctrl_q[6] && gate_q && !gate_i |=> irq_o);

   // R10
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr == 2'd1 |=> cnt_q == $past(wr_data));

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[15] && !(wr_en && wr_addr == 2'd1) |=> $stable(cnt_q));
endmodule

bind mm_timer mm_timer_chk #(.CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .gate_i(gate_i), .irq_o(irq_o), .ctrl_q(ctrl_q), .cnt_q(cnt_q), .per_q(per_q),
   .gate_q(gate_q)
);

// File: tb/mm_timer_tb_top.sv
`timescale 1ns/1ps
module mm_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  rd_addr = 2'd1;
   logic [15:0] rd_data;
   logic        ext = 1'b0;
   logic        gate = 1'b0;
   logic        irq;

   int total = 0;
   int bad = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   mm_timer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .ext_clk_i(ext), .gate_i(gate), .irq_o(irq)
   );

   // behavioural reference model
   logic [15:0] m_ctrl, m_cnt, m_per;
   bit          m_flag, m_ext_prev, m_gate_prev, d1, d2, d3;
   int          m_pcnt;

   always @(posedge clk) begin
      bit e_rise, g_fall, on, cs, sy, ge, gated, cw, kw, src, fire, inc, setf;
      int ratio;
      if (!rst_n) begin
         m_ctrl = 0; m_cnt = 0; m_per = 16'hFFFF; m_flag = 0;
         m_ext_prev = 0; m_gate_prev = 0; d1 = 0; d2 = 0; d3 = 0; m_pcnt = 0;
      end else begin
         e_rise = ext && !m_ext_prev;
         g_fall = !gate && m_gate_prev;
         on = m_ctrl[15]; cs = m_ctrl[1]; sy = m_ctrl[2]; ge = m_ctrl[6];
         gated = !cs && ge;
         cw = wr_en && wr_addr == 0;
         kw = wr_en && wr_addr == 1;
         src = on && (cs ? e_rise : (ge ? gate : 1'b1));
         case (m_ctrl[5:4])
            2'd0: ratio = 1;
            2'd1: ratio = 8;
            2'd2: ratio = 64;
            default: ratio = 256;
         endcase
         fire = 0;
         if (cw || kw) m_pcnt = 0;
         else if (src) begin
            m_pcnt++;
            if (m_pcnt == ratio) begin m_pcnt = 0; fire = 1; end
         end
         inc = (cs && sy) ? (d2 && !d3) : fire;
         if (cw || kw) inc = 0;
         if (cw) begin d1 = 0; d2 = 0; d3 = 0; end
         else begin d3 = d2; d2 = d1; d1 = fire; end
         setf = 0;
         if (kw) m_cnt = wr_data;
         else if (inc) begin
            if (m_cnt == m_per) begin m_cnt = 0; if (!gated) setf = 1; end
            else m_cnt = m_cnt + 1;
         end
         if (on && gated && g_fall) setf = 1;
         if (setf) m_flag = 1;
         else if (wr_en && wr_addr == 3 && !wr_data[0]) m_flag = 0;
         if (cw) m_ctrl = wr_data & 16'h8076;
         if (wr_en && wr_addr == 2) m_per = wr_data;
         m_ext_prev = ext; m_gate_prev = gate;
      end
   end

   task automatic check(string req, logic [15:0] act, logic [15:0] exp, string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      check(cur_req, rd_data, m_cnt, "count");
      check(cur_req, {15'd0, irq}, {15'd0, m_flag}, "irq");
   endtask

   task automatic wr(logic [1:0] a, logic [15:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 0;
   endtask

   task automatic rd_check(string req, logic [1:0] a, logic [15:0] exp);
      rd_addr = a;
      #1;
      check(req, rd_data, exp, "readback");
      rd_addr = 2'd1;
      #1;
   endtask

   // ext_half: cycles between ext toggles (0 = none); gate high/low lengths (0 = none)
   task automatic run(int n, int ext_half, int ghi, int glo);
      for (int i = 0; i < n; i++) begin
         tick();
         if (ext_half > 0 && (i % ext_half) == ext_half - 1) ext = ~ext;
         if (ghi > 0) gate = (i % (ghi + glo)) < ghi;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      cur_req = "R1";
      repeat (3) tick();
      rst_n = 1;
      tick();
      rd_check("R1", 2'd0, 16'h0000);
      rd_check("R1", 2'd2, 16'hFFFF);
      rd_check("R1", 2'd3, 16'h0000);
      rd_check("R1", 2'd1, 16'h0000);

      // R12 register map and control masking
      cur_req = "R12";
      wr(2'd2, 16'd5);
      rd_check("R12", 2'd2, 16'd5);
      wr(2'd0, 16'h7F89);
      rd_check("R12", 2'd0, 16'h0000);

      // R2 / R3: plain timer 1:1 with the sync bit set (ignored)
      cur_req = "R2_R3";
      wr(2'd0, 16'h8004);
      rd_check("R12", 2'd0, 16'h8004);
      run(20, 0, 0, 0);

      // R4: write 1 has no effect, write 0 clears, held clear over a wrap
      cur_req = "R4";
      wr(2'd3, 16'h0001);
      rd_check("R4", 2'd3, {15'd0, m_flag});
      wr(2'd3, 16'h0000);
      for (int i = 0; i < 12; i++) begin
         wr_en = 1; wr_addr = 2'd3; wr_data = 16'h0000;
         tick();
      end
      wr_en = 0;
      run(3, 0, 0, 0);

      // R5: prescale ratios
      cur_req = "R5";
      wr(2'd2, 16'd2);
      wr(2'd0, 16'h8010);
      run(60, 0, 0, 0);
      wr(2'd0, 16'h8020);
      run(300, 0, 0, 0);
      wr(2'd0, 16'h8030);
      run(1000, 0, 0, 0);

      // R11: stopped timer holds count
      cur_req = "R11";
      wr(2'd0, 16'h0040);
      run(30, 2, 3, 2);

      // R6 / R7: gated timer
      cur_req = "R6_R7";
      wr(2'd3, 16'h0000);
      wr(2'd1, 16'h0000);
      wr(2'd2, 16'h0040);
      wr(2'd0, 16'h8040);
      run(90, 0, 10, 5);
      wr(2'd3, 16'h0000);
      wr(2'd2, 16'd3);
      gate = 1;
      run(20, 0, 0, 0);
      gate = 0;
      run(5, 0, 0, 0);

      // R8: direct external counter
      cur_req = "R8";
      wr(2'd3, 16'h0000);
      wr(2'd2, 16'd4);
      wr(2'd0, 16'h8002);
      run(80, 1, 0, 0);
      run(60, 3, 0, 0);
      wr(2'd0, 16'h8012);
      run(200, 1, 0, 0);

      // R9: resynchronized counter, gate enable ignored
      cur_req = "R9";
      wr(2'd3, 16'h0000);
      wr(2'd0, 16'h8046);
      run(80, 1, 4, 3);
      run(60, 3, 2, 2);
      wr(2'd0, 16'h8056);
      run(200, 1, 0, 0);

      // R10: count load and control write clear prescaler and pending pulses
      cur_req = "R10";
      wr(2'd0, 16'h8006);
      ext = 0; tick(); ext = 1;
      wr(2'd0, 16'h8006);
      run(6, 0, 0, 0);
      wr(2'd2, 16'h0200);
      wr(2'd0, 16'h8010);
      run(5, 0, 0, 0);
      wr(2'd1, 16'h0100);
      run(20, 0, 0, 0);
      wr(2'd0, 16'h8010);
      run(20, 0, 0, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule